// File: doc/BRIEF.md
# Region Protection Address Translator

This block turns a virtual address into a physical address and a set of access rights for a core that has no paging unit. The three most significant address bits pick one of eight equal regions of the address space. Each region has a small entry: the top bits of a physical base and a 4-bit attribute code. The code decodes into read, write and execute rights plus a cache mode. A request that the decoded rights do not permit comes back with a fault cause that tells a load, a store and an instruction fetch apart.

Two entry sets are kept: fetches look up the instruction set, loads and stores the data set. Entries are written through a single-cycle write port that names the set, the region and the new contents. With the region mode input low, the entries are bypassed: the address passes through unchanged and the attribute code is the 4-bit slice of a cache-attribute word that the region index selects. One result is produced per request, registered, one cycle after the request.

Top module: `region_xlat`

## Requirements
- R1: After a synchronous active-low reset, res_valid is 0 and every entry of both sets maps region i to physical base i (identity) with attribute code 2.
- R2: res_valid is 1 in the cycle after a cycle with acc_valid high and 0 in the cycle after a cycle with acc_valid low.
- R3: In region mode the region index is acc_vaddr[31:29]; res_pa is the entry's 3-bit base in bits 31:29 and acc_vaddr[28:0] below.
- R4: Attribute codes decode, with res_rights = {execute, write, read} and res_cache 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate: code 0 gives read+write, write-through; 1 gives read+write+execute, write-through; 2 gives read+write+execute, bypass; 3 gives execute only, write-back; 4 and 5 give read+write+execute, write-back; 14 gives read+write, isolate; every other code gives no rights and cache 0.
- R5: With mode_region low, res_pa equals acc_vaddr, the attribute code is acc_cattr[4*idx+3 : 4*idx] for the region index idx, and code 5 there gives no rights and cache 0 (all other codes decode as in R4).
- R6: res_fault is 1 for a load (acc_fetch 0, acc_write 0) without read right, 2 for a store (acc_fetch 0, acc_write 1) without write right, 3 for a fetch (acc_fetch 1, acc_write ignored) without execute right, and 0 when the right is present.
- R7: A fetch uses the instruction set, a load or store the data set; a write with wr_side 0 changes only the instruction set, with wr_side 1 only the data set.
- R8: A lookup in the same cycle as a write to its entry sees the old entry and the new one from the next cycle on; only wr_base[31:29] is kept.
- R9: While res_valid is 0, res_pa, res_rights, res_cache and res_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_region | input | 1 | 1: use region entries, 0: identity with cache-attribute word |
| acc_cattr | input | 32 | Cache-attribute word, one 4-bit code per region |
| acc_valid | input | 1 | Lookup request |
| acc_vaddr | input | 32 | Virtual address |
| acc_write | input | 1 | Store when set (data side) |
| acc_fetch | input | 1 | Instruction fetch when set |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 instruction set, 1 data set |
| wr_idx | input | 3 | Region entry to write |
| wr_base | input | 32 | New physical base (bits 31:29 kept) |
| wr_attr | input | 4 | New attribute code |
| res_valid | output | 1 | Result valid |
| res_pa | output | 32 | Physical address |
| res_rights | output | 3 | {execute, write, read} |
| res_cache | output | 3 | Cache mode code |
| res_fault | output | 2 | Fault cause code |

## Verification
The bench builds the block with its default parameters: a 32-bit address and three index bits, so all eight regions, the whole 16-value attribute space and every nibble of the cache-attribute word are reachable with short random runs. Directed cases cover the reset identity map, code 5 in both modes, the execute-only code against loads and stores, a fetch that must ignore a data-side write, and a write colliding with a lookup of the same entry.

// File: rtl/region_xlat_pkg.sv
// Shared types of the region translator: cache mode codes, fault codes and
// the decoded permission record. Assumes nothing beyond 1800-2017 packages.
package region_xlat_pkg;

    typedef enum logic [2:0] {
        CM_NONE   = 3'd0,
        CM_BYPASS = 3'd1,
        CM_WTHRU  = 3'd2,
        CM_WBACK  = 3'd3,
        CM_ISOL   = 3'd4
    } cache_mode_e;

    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_LOAD  = 2'd1,
        FC_STORE = 2'd2,
        FC_FETCH = 2'd3
    } fault_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        rights_t     rights;
        cache_mode_e cmode;
    } perm_t;

endpackage

// File: rtl/region_attr_dec.sv
// Attribute decoder: maps a 4-bit attribute code to rights and cache mode.
// Assumes: fallback=1 selects the cache-attribute-word variant, in which
// code 5 grants nothing. Purely combinational.
module region_attr_dec
    import region_xlat_pkg::*;
#(
    parameter int ATTR_W = 4
) (
    input  logic [ATTR_W-1:0] attr,
    input  logic              fallback,
    output perm_t             perm
);

    // Table lookup of rights and cache mode for one code.
    always_comb begin
        perm = '{rights: '{x: 1'b0, w: 1'b0, r: 1'b0}, cmode: CM_NONE};
        case (attr)
            ATTR_W'(0):  perm = '{rights: '{x: 1'b0, w: 1'b1, r: 1'b1}, cmode: CM_WTHRU};
            ATTR_W'(1):  perm = '{rights: '{x: 1'b1, w: 1'b1, r: 1'b1}, cmode: CM_WTHRU};
            ATTR_W'(2):  perm = '{rights: '{x: 1'b1, w: 1'b1, r: 1'b1}, cmode: CM_BYPASS};
            ATTR_W'(3):  perm = '{rights: '{x: 1'b1, w: 1'b0, r: 1'b0}, cmode: CM_WBACK};
            ATTR_W'(4):  perm = '{rights: '{x: 1'b1, w: 1'b1, r: 1'b1}, cmode: CM_WBACK};
            ATTR_W'(5): begin
                if (!fallback)
                    perm = '{rights: '{x: 1'b1, w: 1'b1, r: 1'b1}, cmode: CM_WBACK};
            end
            ATTR_W'(14): perm = '{rights: '{x: 1'b0, w: 1'b1, r: 1'b1}, cmode: CM_ISOL};
            default: ;
        endcase
    end

endmodule

// File: rtl/region_table.sv
// One set of region entries (base top bits + attribute), with a single
// write port and one asynchronous read port. Assumes synchronous active-low
// reset; reset loads the identity map with RESET_ATTR.
module region_table #(
    parameter int IDX_W      = 3,
    parameter int ATTR_W     = 4,
    parameter int RESET_ATTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  rd_base,
    output logic [ATTR_W-1:0] rd_attr
);

    localparam int NREG = 1 << IDX_W;

    logic [IDX_W-1:0]  base_q [NREG];
    logic [ATTR_W-1:0] attr_q [NREG];

    // Entry storage: identity reset, single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                base_q[i] <= IDX_W'(i);
                attr_q[i] <= ATTR_W'(RESET_ATTR);
            end
        end else if (wr_en) begin
            base_q[wr_idx] <= wr_base;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    // Read port: entry of the requested region.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_attr = attr_q[rd_idx];
    end

endmodule

// File: rtl/region_xlat.sv
// Region protection translator top. Picks the region from the top address
// bits, reads the instruction or data entry set (or the cache-attribute
// word in fallback mode), decodes rights and registers address, rights,
// cache mode and fault cause one cycle later. Assumes synchronous
// active-low reset and that acc_cattr is stable with the request.
module region_xlat
    import region_xlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int ATTR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_region,
    input  logic [(ATTR_W<<IDX_W)-1:0] acc_cattr,
    input  logic                       acc_valid,
    input  logic [ADDR_W-1:0]          acc_vaddr,
    input  logic                       acc_write,
    input  logic                       acc_fetch,
    input  logic                       wr_en,
    input  logic                       wr_side,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [ADDR_W-1:0]          wr_base,
    input  logic [ATTR_W-1:0]          wr_attr,
    output logic                       res_valid,
    output logic [ADDR_W-1:0]          res_pa,
    output logic [2:0]                 res_rights,
    output logic [2:0]                 res_cache,
    output logic [1:0]                 res_fault
);

    localparam int OFS_W  = ADDR_W - IDX_W;
    localparam int NSIDE  = 2;

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  tb_base [NSIDE];
    logic [ATTR_W-1:0] tb_attr [NSIDE];
    logic              rd_side;
    logic [ATTR_W-1:0] attr_sel;
    logic [ADDR_W-1:0] pa_next;
    perm_t             perm;
    logic              granted;
    fault_e            fault_next;

    assign idx     = acc_vaddr[ADDR_W-1 -: IDX_W];
    assign rd_side = ~acc_fetch;

    // Side 0 holds instruction entries, side 1 data entries.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        region_table #(
            .IDX_W     (IDX_W),
            .ATTR_W    (ATTR_W),
            .RESET_ATTR(2)
        ) u_table (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && (wr_side == 1'(s))),
            .wr_idx (wr_idx),
            .wr_base(wr_base[ADDR_W-1 -: IDX_W]),
            .wr_attr(wr_attr),
            .rd_idx (idx),
            .rd_base(tb_base[s]),
            .rd_attr(tb_attr[s])
        );
    end

    // Attribute source and physical address for the current mode.
    always_comb begin
        if (mode_region) begin
            attr_sel = tb_attr[rd_side];
            pa_next  = {tb_base[rd_side], acc_vaddr[OFS_W-1:0]};
        end else begin
            attr_sel = acc_cattr[idx*ATTR_W +: ATTR_W];
            pa_next  = acc_vaddr;
        end
    end

    region_attr_dec #(
        .ATTR_W(ATTR_W)
    ) u_dec (
        .attr    (attr_sel),
        .fallback(~mode_region),
        .perm    (perm)
    );

    // Right check for the access kind and the matching fault cause.
    always_comb begin
        if (acc_fetch)      granted = perm.rights.x;
        else if (acc_write) granted = perm.rights.w;
        else                granted = perm.rights.r;
        if (granted)        fault_next = FC_NONE;
        else if (acc_fetch) fault_next = FC_FETCH;
        else if (acc_write) fault_next = FC_STORE;
        else                fault_next = FC_LOAD;
    end

    // Result register: one result per request, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !acc_valid) begin
            res_valid  <= 1'b0;
            res_pa     <= '0;
            res_rights <= '0;
            res_cache  <= '0;
            res_fault  <= '0;
        end else begin
            res_valid  <= 1'b1;
            res_pa     <= pa_next;
            res_rights <= perm.rights;
            res_cache  <= perm.cmode;
            res_fault  <= fault_next;
        end
    end

endmodule

// File: rtl/region_xlat_chk.sv
// Property checker for region_xlat, attached by bind. Observes ports only.
module region_xlat_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    parameter int ATTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_region,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_vaddr,
    input logic              acc_fetch,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pa,
    input logic [2:0]        res_rights,
    input logic [2:0]        res_cache,
    input logic [1:0]        res_fault
);

    localparam int OFS_W = ADDR_W - IDX_W;

    assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    assert_idle_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_pa[OFS_W-1:0] == $past(acc_vaddr[OFS_W-1:0]));

    assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_region) |=> res_pa == $past(acc_vaddr));

    assert_isolate_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_cache == 3'd4) |-> (res_rights == 3'b011));

    assert_load_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault == 2'd1) |-> !res_rights[0]);

    assert_store_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault == 2'd2) |-> !res_rights[1]);

    assert_fetch_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fetch) |=> (res_fault == 2'd0 || res_fault == 2'd3));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_pa == '0 && res_fault == 2'd0 && res_rights == 3'd0));

endmodule

bind region_xlat region_xlat_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .ATTR_W(ATTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_region(mode_region),
    .acc_valid  (acc_valid),
    .acc_vaddr  (acc_vaddr),
    .acc_fetch  (acc_fetch),
    .res_valid  (res_valid),
    .res_pa     (res_pa),
    .res_rights (res_rights),
    .res_cache  (res_cache),
    .res_fault  (res_fault)
);

// File: tb/region_xlat_tb.sv
module region_xlat_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_region = 1'b1;
    logic [31:0] acc_cattr = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_side = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [3:0]  wr_attr = '0;
    logic        res_valid;
    logic [31:0] res_pa;
    logic [2:0]  res_rights;
    logic [2:0]  res_cache;
    logic [1:0]  res_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] m_base [2][8];
    logic [3:0] m_attr [2][8];

    always #4 clk = ~clk;

    region_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .mode_region(mode_region), .acc_cattr(acc_cattr),
        .acc_valid(acc_valid), .acc_vaddr(acc_vaddr), .acc_write(acc_write),
        .acc_fetch(acc_fetch), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_attr(wr_attr), .res_valid(res_valid), .res_pa(res_pa),
        .res_rights(res_rights), .res_cache(res_cache), .res_fault(res_fault)
    );

    // Expected {x,w,r,cache} for one code, per R4 and R5.
    function automatic logic [5:0] exp_perm(input logic [3:0] a, input logic fb);
        case (a)
            4'd0:  return {3'b011, 3'd2};
            4'd1:  return {3'b111, 3'd2};
            4'd2:  return {3'b111, 3'd1};
            4'd3:  return {3'b100, 3'd3};
            4'd4:  return {3'b111, 3'd3};
            4'd5:  return fb ? 6'd0 : {3'b111, 3'd3};
            4'd14: return {3'b011, 3'd4};
            default: return 6'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin
                m_base[s][i] = 3'(i);
                m_attr[s][i] = 4'd2;
            end
    endtask

    // One cycle: drive at negedge, sample after the next posedge.
    task automatic op(input string tag, input logic v, input logic [31:0] va,
                      input logic wr, input logic fe, input logic md,
                      input logic [31:0] ca, input logic we, input logic ws,
                      input logic [2:0] wi, input logic [31:0] wb,
                      input logic [3:0] wa);
        logic [2:0]  ix;
        logic        sd;
        logic [3:0]  at;
        logic [5:0]  pm;
        logic [31:0] epa;
        logic [1:0]  ef;
        logic        ok;
        @(negedge clk);
        mode_region = md; acc_cattr = ca; acc_valid = v; acc_vaddr = va;
        acc_write = wr; acc_fetch = fe; wr_en = we; wr_side = ws; wr_idx = wi;
        wr_base = wb; wr_attr = wa;
        ix = va[31:29];
        sd = ~fe;
        if (md) begin
            at  = m_attr[sd][ix];
            epa = {m_base[sd][ix], va[28:0]};
        end else begin
            at  = ca[ix*4 +: 4];
            epa = va;
        end
        pm = exp_perm(at, ~md);
        ok = fe ? pm[5] : (wr ? pm[4] : pm[3]);
        ef = ok ? 2'd0 : (fe ? 2'd3 : (wr ? 2'd2 : 2'd1));
        if (!v) begin
            epa = '0; pm = '0; ef = '0;
        end
        @(posedge clk);
        #1;
        if (we) begin
            m_base[ws][wi] = wb[31:29];
            m_attr[ws][wi] = wa;
        end
        chk(tag, "res_valid", 32'(res_valid), 32'(v));
        chk(tag, "res_pa", res_pa, epa);
        chk(tag, "res_rights", 32'(res_rights), 32'(pm[5:3]));
        chk(tag, "res_cache", 32'(res_cache), 32'(pm[2:0]));
        chk(tag, "res_fault", 32'(res_fault), 32'(ef));
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic wr,
                        input logic fe, input logic md, input logic [31:0] ca);
        op(tag, 1'b1, va, wr, fe, md, ca, 1'b0, 1'b0, 3'd0, 32'd0, 4'd0);
    endtask

    task automatic wrt(input string tag, input logic ws, input logic [2:0] wi,
                       input logic [31:0] wb, input logic [3:0] wa);
        op(tag, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1, 32'd0, 1'b1, ws, wi, wb, wa);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "res_valid in reset", 32'(res_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map with code 2 on both sides.
        for (int i = 0; i < 8; i++) begin
            look("R1", {3'(i), 29'h0123_4567}, 1'b0, 1'b0, 1'b1, 32'd0);
            look("R1", {3'(i), 29'h0000_0abc}, 1'b0, 1'b1, 1'b1, 32'd0);
        end

        // R3/R4: data entry 3 -> base 6, code 5.
        wrt("R3", 1'b1, 3'd3, 32'hC000_0000, 4'd5);
        look("R3", 32'h7ABC_DEF0, 1'b1, 1'b0, 1'b1, 32'd0);
        // R5: code 5 through the cache-attribute word grants nothing.
        look("R5", 32'h6000_0010, 1'b0, 1'b0, 1'b0, 32'h0000_5000);
        look("R5", 32'hE000_0020, 1'b1, 1'b0, 1'b0, 32'hE000_0000);

        // R6/R4: execute-only code on the data side.
        wrt("R6", 1'b1, 3'd2, 32'h4000_0000, 4'd3);
        look("R6", 32'h4000_0100, 1'b0, 1'b0, 1'b1, 32'd0);
        look("R6", 32'h4000_0104, 1'b1, 1'b0, 1'b1, 32'd0);
        // R7: fetch from the same region uses the untouched instruction side.
        look("R7", 32'h4000_0108, 1'b0, 1'b1, 1'b1, 32'd0);
        // R4: isolate and an unassigned code.
        wrt("R4", 1'b0, 3'd1, 32'h2000_0000, 4'd14);
        look("R4", 32'h2000_0000, 1'b1, 1'b0, 1'b1, 32'd0);
        look("R4", 32'h2000_0004, 1'b0, 1'b1, 1'b1, 32'd0);
        wrt("R4", 1'b1, 3'd5, 32'hFFFF_FFFF, 4'd9);
        look("R4", 32'hA000_0000, 1'b0, 1'b0, 1'b1, 32'd0);

        // R8: write and lookup of the same entry in one cycle.
        op("R8", 1'b1, 32'h8000_0040, 1'b0, 1'b0, 1'b1, 32'd0, 1'b1, 1'b1, 3'd4,
           32'h3FFF_FFFF, 4'd7);
        look("R8", 32'h8000_0040, 1'b0, 1'b0, 1'b1, 32'd0);

        // R9/R2: idle cycle.
        op("R9", 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 32'd0, 1'b0, 1'b0, 3'd0,
           32'd0, 4'd0);

        // Random mix of writes and lookups in both modes.
        for (int k = 0; k < 3000; k++) begin
            op("R3", 1'($urandom_range(0, 3) != 0), $urandom, 1'($urandom),
               1'($urandom), 1'($urandom_range(0, 3) != 0), $urandom,
               1'($urandom_range(0, 2) == 0), 1'($urandom), 3'($urandom),
               $urandom, 4'($urandom));
        end

        done = 1'b1;
        finish_run();
    end

endmodule